// File: doc/BRIEF.md
# Serial Port Interrupt Identification

This unit gathers the interrupt sources of a serial port and exposes them to software. It keeps a four-bit interrupt-enable register. It latches line-status error events and transmitter-empty events, and it tracks the four modem input lines, latching a change flag for each one. Each clock it picks the highest-priority enabled cause. It presents that cause as an identification byte and drives one interrupt output. That output passes through a master gate bit owned by the modem-control logic.

Software writes the enable register through a write strobe. It reads the identification byte and the modem status byte, and strobes the matching read pulse so the unit can clear the state that read consumes. All outputs are flops. Every output reflects the inputs sampled at a clock edge right after that edge. A loopback mode takes the modem status levels from the port's own modem-control outputs instead of the external pins, which allows self-test.

Top module: `sio_irq_ident`

## Requirements
- R1: After reset, `ier_val` reads 0x00, `iid_val` reads 0x01, `msr_val` reads 0x00 and `irq` is low.
- R2: A `wr_ier` pulse stores `wr_data` in `ier_val[3:0]` one clock later. Bit 0 enables receive, bit 1 transmit-empty, bit 2 line status and bit 3 modem status. `ier_val[7:4]` always reads 0.
- R3: With no enabled cause pending, `iid_val` is 0x01 (bit 0 = 1 means none pending) when buffering is off, and `irq` is low.
- R4: An enabled pending cause clears `iid_val[0]` and sets `iid_val[2:1]`. Priority from high to low is line status (11), then receive ready or timeout (10), then transmit empty (01), then modem change (00). A cause whose enable bit is 0 is never reported.
- R5: `iid_val[3]` is 1 only when the reported code is 10, `rx_timeout` is high and `fifo_en` is high.
- R6: `iid_val[7:6]` reads 11 when `fifo_en` is high and 00 when it is low. `iid_val[5:4]` reads 0.
- R7: A one-clock `ls_err` pulse latches a line-status cause, and `rd_lsr` clears it. A pulse in the same clock as `rd_lsr` leaves the cause set.
- R8: A rising edge of `thr_empty` latches a transmit-empty cause. The cause clears when `thr_empty` goes low. It also clears when `rd_iid` is strobed while `iid_val[3:0]` shows 0010. A read that shows another code leaves it pending.
- R9: `msr_val` bits 7,6,5,4 are the live DCD, RI, DSR, CTS levels. Bits 3,2,1,0 are their change flags dDCD, dRI, dDSR, dCTS.
- R10: A change flag sets on any level change of its line and stays set until `rd_msr`. A change in the same clock as `rd_msr` leaves that flag set.
- R11: `irq` equals `mc_out2` AND (any enabled cause pending). With `mc_out2` low, `irq` stays low but `iid_val` still shows the cause.
- R12: With `loop_en` high, CTS follows `mc_rts`, DSR follows `mc_dtr`, RI follows `mc_out1` and DCD follows `mc_out2`. The external line inputs then have no effect on `msr_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ier | input | 1 | Enable register write strobe |
| wr_data | input | 4 | Enable register write data |
| rd_iid | input | 1 | Identification byte read strobe |
| rd_lsr | input | 1 | Line status read strobe (clears line-status cause) |
| rd_msr | input | 1 | Modem status read strobe (clears change flags) |
| fifo_en | input | 1 | Buffered mode active |
| loop_en | input | 1 | Loopback self-test mode |
| mc_dtr | input | 1 | Modem-control DTR output level |
| mc_rts | input | 1 | Modem-control RTS output level |
| mc_out1 | input | 1 | Modem-control auxiliary output 1 |
| mc_out2 | input | 1 | Modem-control auxiliary output 2, master interrupt gate |
| ls_err | input | 1 | Line-status error event pulse |
| rx_ready | input | 1 | Receive data available level |
| rx_timeout | input | 1 | Receive character timeout level |
| thr_empty | input | 1 | Transmit holding register empty level |
| line_cts | input | 1 | External CTS level |
| line_dsr | input | 1 | External DSR level |
| line_ri | input | 1 | External RI level |
| line_dcd | input | 1 | External DCD level |
| ier_val | output | 8 | Enable register read value |
| iid_val | output | 8 | Identification byte |
| msr_val | output | 8 | Modem status byte |
| irq | output | 1 | Interrupt request |

## Verification
The collisions that matter are a set event arriving in the same clock as the read that clears it. One case is `ls_err` together with `rd_lsr`. The other is a modem line edge together with `rd_msr`. The bench drives both in one cycle and checks that the flag survives the read. It also strobes `rd_iid` while a higher-priority receive cause hides a pending transmit-empty cause, and checks that the transmit cause appears once the receive cause goes away. A behavioural model updated on every clock is compared with all four outputs, and directed checks with fixed expected bytes sit at each corner.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;
  localparam int REG_W  = 8;
  localparam int IER_W  = 4;
  localparam int MLINES = 4;

  // enable bit positions
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LS = 2;
  localparam int EN_MS = 3;

  typedef enum logic [1:0] {
    CAUSE_MODEM = 2'b00,
    CAUSE_TX    = 2'b01,
    CAUSE_RX    = 2'b10,
    CAUSE_LINE  = 2'b11
  } cause_e;
endpackage

// File: rtl/sio_msr_track.sv
module sio_msr_track #(
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_msr,
  input  logic             loop_en,
  input  logic [LINES-1:0] ext_lines,
  input  logic [LINES-1:0] loop_lines,
  output logic [LINES-1:0] live_q,
  output logic [LINES-1:0] delta_q,
  output logic             delta_any_nx
);
  logic             vld_q;
  logic [LINES-1:0] src;
  logic [LINES-1:0] delta_nx;

  assign src = loop_en ? loop_lines : ext_lines;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= 1'b1;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign delta_nx[i] = (rd_msr ? 1'b0 : delta_q[i]) | (vld_q & (src[i] ^ live_q[i]));

    always_ff @(posedge clk) begin
      if (rst) begin
        live_q[i]  <= 1'b0;
        delta_q[i] <= 1'b0;
      end else begin
        live_q[i]  <= src[i];
        delta_q[i] <= delta_nx[i];
      end
    end

    // R10: a change flag only rises when its live level moved
    p_delta_src_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(delta_q[i]) |-> (live_q[i] != $past(live_q[i])));
  end

  assign delta_any_nx = |delta_nx;
endmodule

// File: rtl/sio_cause_latch.sv
module sio_cause_latch (
  input  logic clk,
  input  logic rst,
  input  logic ls_err,
  input  logic rd_lsr,
  input  logic thr_empty,
  input  logic tx_clr,
  output logic ls_nx,
  output logic tx_nx
);
  logic ls_q;
  logic tx_q;
  logic thr_prev_q;

  always_comb begin
    ls_nx = ls_err ? 1'b1 : (rd_lsr ? 1'b0 : ls_q);
    if (!thr_empty)       tx_nx = 1'b0;
    else if (!thr_prev_q) tx_nx = 1'b1;
    else if (tx_clr)      tx_nx = 1'b0;
    else                  tx_nx = tx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_q       <= 1'b0;
      tx_q       <= 1'b0;
      thr_prev_q <= 1'b0;
    end else begin
      ls_q       <= ls_nx;
      tx_q       <= tx_nx;
      thr_prev_q <= thr_empty;
    end
  end

  // R7: an error pulse is never lost to a simultaneous clear
  p_ls_hold_r7: assert property (@(posedge clk) disable iff (rst)
    $past(ls_err) |-> ls_q);
  // R8: transmit cause only drops on a read clear or on a full holding register
  p_tx_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_q) |-> ($past(tx_clr) || !$past(thr_empty)));
endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int EW = IER_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [EW-1:0] ier_nx,
  input  logic          ls_nx,
  input  logic          rx_ready,
  input  logic          rx_timeout,
  input  logic          tx_nx,
  input  logic          ms_nx,
  input  logic          fifo_en,
  input  logic          gate,
  output logic [W-1:0]  iid_q,
  output logic          irq_q
);
  logic   ls_act, rx_act, tx_act, ms_act, any_act, to_bit;
  cause_e code;
  logic [W-1:0] iid_d;

  always_comb begin
    ls_act  = ier_nx[EN_LS] & ls_nx;
    rx_act  = ier_nx[EN_RX] & (rx_ready | rx_timeout);
    tx_act  = ier_nx[EN_TX] & tx_nx;
    ms_act  = ier_nx[EN_MS] & ms_nx;
    any_act = ls_act | rx_act | tx_act | ms_act;
    if (ls_act)      code = CAUSE_LINE;
    else if (rx_act) code = CAUSE_RX;
    else if (tx_act) code = CAUSE_TX;
    else             code = CAUSE_MODEM;
    to_bit = !ls_act && rx_act && rx_timeout && fifo_en;
    iid_d  = '0;
    iid_d[0]   = ~any_act;
    iid_d[2:1] = code;
    iid_d[3]   = to_bit;
    iid_d[W-1] = fifo_en;
    iid_d[W-2] = fifo_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iid_q <= W'(1);
      irq_q <= 1'b0;
    end else begin
      iid_q <= iid_d;
      irq_q <= gate & any_act;
    end
  end

  p_timeout_code_r5: assert property (@(posedge clk) disable iff (rst)
    iid_q[3] |-> (iid_q[2:1] == 2'b10));
  p_gate_r11: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(gate));
  p_idle_r3: assert property (@(posedge clk) disable iff (rst)
    iid_q[0] |-> !irq_q);
endmodule

// File: rtl/sio_irq_ident.sv
module sio_irq_ident
  import sio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ier,
  input  logic [IER_W-1:0] wr_data,
  input  logic             rd_iid,
  input  logic             rd_lsr,
  input  logic             rd_msr,
  input  logic             fifo_en,
  input  logic             loop_en,
  input  logic             mc_dtr,
  input  logic             mc_rts,
  input  logic             mc_out1,
  input  logic             mc_out2,
  input  logic             ls_err,
  input  logic             rx_ready,
  input  logic             rx_timeout,
  input  logic             thr_empty,
  input  logic             line_cts,
  input  logic             line_dsr,
  input  logic             line_ri,
  input  logic             line_dcd,
  output logic [REG_W-1:0] ier_val,
  output logic [REG_W-1:0] iid_val,
  output logic [REG_W-1:0] msr_val,
  output logic             irq
);
  localparam int PAD_W = REG_W - IER_W;

  logic [IER_W-1:0]  ier_q, ier_nx;
  logic              ls_nx, tx_nx, ms_nx, tx_clr;
  logic [MLINES-1:0] live_q, delta_q;

  assign ier_nx = wr_ier ? wr_data : ier_q;

  always_ff @(posedge clk) begin
    if (rst) ier_q <= '0;
    else     ier_q <= ier_nx;
  end

  // a read only consumes the transmit cause it actually presented
  assign tx_clr = rd_iid && (iid_val[3:0] == 4'b0010);

  sio_cause_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .ls_err    (ls_err),
    .rd_lsr    (rd_lsr),
    .thr_empty (thr_empty),
    .tx_clr    (tx_clr),
    .ls_nx     (ls_nx),
    .tx_nx     (tx_nx)
  );

  // line order: [0] CTS, [1] DSR, [2] RI, [3] DCD
  sio_msr_track #(.LINES(MLINES)) u_msr (
    .clk          (clk),
    .rst          (rst),
    .rd_msr       (rd_msr),
    .loop_en      (loop_en),
    .ext_lines    ({line_dcd, line_ri, line_dsr, line_cts}),
    .loop_lines   ({mc_out2, mc_out1, mc_dtr, mc_rts}),
    .live_q       (live_q),
    .delta_q      (delta_q),
    .delta_any_nx (ms_nx)
  );

  sio_irq_prio #(.W(REG_W), .EW(IER_W)) u_prio (
    .clk        (clk),
    .rst        (rst),
    .ier_nx     (ier_nx),
    .ls_nx      (ls_nx),
    .rx_ready   (rx_ready),
    .rx_timeout (rx_timeout),
    .tx_nx      (tx_nx),
    .ms_nx      (ms_nx),
    .fifo_en    (fifo_en),
    .gate       (mc_out2),
    .iid_q      (iid_val),
    .irq_q      (irq)
  );

  assign ier_val = {{PAD_W{1'b0}}, ier_q};
  assign msr_val = {live_q, delta_q};

  p_ier_track_r2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_ier) |-> (ier_val[IER_W-1:0] == $past(wr_data)));
  p_gate_iid_r11: assert property (@(posedge clk) disable iff (rst)
    $past(mc_out2) |-> (irq == !iid_val[0]));
endmodule

// File: tb/sio_irq_ident_test.sv
module sio_irq_ident_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_ier = 0, rd_iid = 0, rd_lsr = 0, rd_msr = 0;
  logic [3:0] wr_data = '0;
  logic fifo_en = 0, loop_en = 0, mc_dtr = 0, mc_rts = 0, mc_out1 = 0, mc_out2 = 0;
  logic ls_err = 0, rx_ready = 0, rx_timeout = 0, thr_empty = 0;
  logic line_cts = 0, line_dsr = 0, line_ri = 0, line_dcd = 0;
  logic [7:0] ier_val, iid_val, msr_val;
  logic irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sio_irq_ident uut (
    .clk(clk), .rst(rst), .wr_ier(wr_ier), .wr_data(wr_data), .rd_iid(rd_iid),
    .rd_lsr(rd_lsr), .rd_msr(rd_msr), .fifo_en(fifo_en), .loop_en(loop_en),
    .mc_dtr(mc_dtr), .mc_rts(mc_rts), .mc_out1(mc_out1), .mc_out2(mc_out2),
    .ls_err(ls_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout), .thr_empty(thr_empty),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_ri(line_ri), .line_dcd(line_dcd),
    .ier_val(ier_val), .iid_val(iid_val), .msr_val(msr_val), .irq(irq)
  );

  // behavioural reference model
  logic [3:0] m_ier;
  bit m_ls, m_tx, m_thr_prev, m_vld, m_irq;
  logic [3:0] m_live, m_delta;   // index 3 DCD, 2 RI, 1 DSR, 0 CTS
  logic [7:0] m_iid;

  always @(posedge clk) begin
    if (rst) begin
      m_ier = 0; m_ls = 0; m_tx = 0; m_thr_prev = 0; m_vld = 0;
      m_live = 0; m_delta = 0; m_iid = 8'h01; m_irq = 0;
    end else begin
      logic [3:0] src;
      int code;
      bit lsa, rxa, txa, msa, any, to;
      if (wr_ier) m_ier = wr_data;
      if (ls_err) m_ls = 1; else if (rd_lsr) m_ls = 0;
      if (!thr_empty) m_tx = 0;
      else if (!m_thr_prev) m_tx = 1;
      else if (rd_iid && m_iid[3:0] == 4'h2) m_tx = 0;
      m_thr_prev = thr_empty;
      src = loop_en ? {mc_out2, mc_out1, mc_dtr, mc_rts} : {line_dcd, line_ri, line_dsr, line_cts};
      if (rd_msr) m_delta = 0;
      if (m_vld) m_delta = m_delta | (src ^ m_live);
      m_live = src; m_vld = 1;
      lsa = m_ier[2] && m_ls;
      rxa = m_ier[0] && (rx_ready || rx_timeout);
      txa = m_ier[1] && m_tx;
      msa = m_ier[3] && (m_delta != 0);
      any = lsa || rxa || txa || msa;
      code = lsa ? 3 : rxa ? 2 : txa ? 1 : 0;
      to = !lsa && rxa && rx_timeout && fifo_en;
      m_iid = {fifo_en, fifo_en, 2'b00, to, code[1:0], !any};
      m_irq = mc_out2 && any;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 ier", ier_val, {4'h0, m_ier});
    chk("R4 iid", iid_val, m_iid);
    chk("R9 msr", msr_val, {m_live, m_delta});
    chk("R11 irq", {7'h0, irq}, {7'h0, m_irq});
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    chk("R1 ier", ier_val, 8'h00); chk("R1 iid", iid_val, 8'h01);
    chk("R1 msr", msr_val, 8'h00); chk("R1 irq", {7'h0, irq}, 8'h00);
    rst = 0; tick();
    // R2
    wr_ier = 1; wr_data = 4'hF; tick(); wr_ier = 0;
    chk("R2", ier_val, 8'h0F);
    chk("R3 iid", iid_val, 8'h01); chk("R3 irq", {7'h0, irq}, 8'h00);
    mc_out2 = 1; tick();
    // R4 priority and R7 latch
    rx_ready = 1; tick(); chk("R4 rx", iid_val, 8'h04); chk("R11 on", {7'h0, irq}, 8'h01);
    ls_err = 1; tick(); ls_err = 0; chk("R4 ls over rx", iid_val, 8'h06);
    tick(); chk("R7 held", iid_val, 8'h06);
    rd_lsr = 1; tick(); rd_lsr = 0; chk("R7 clr", iid_val, 8'h04);
    ls_err = 1; rd_lsr = 1; tick(); ls_err = 0; rd_lsr = 0; chk("R7 collide", iid_val, 8'h06);
    // R5 / R6
    fifo_en = 1; rx_ready = 0; rx_timeout = 1; tick(); chk("R5 ls wins", iid_val, 8'hC6);
    rd_lsr = 1; tick(); rd_lsr = 0; chk("R5 timeout", iid_val, 8'hCC);
    fifo_en = 0; tick(); chk("R6 char mode", iid_val, 8'h04);
    rx_timeout = 0; tick(); chk("R3 idle", iid_val, 8'h01);
    // R8
    thr_empty = 1; tick(); chk("R8 set", iid_val, 8'h02);
    rd_iid = 1; tick(); rd_iid = 0; chk("R8 read clr", iid_val, 8'h01);
    tick(); chk("R8 stays clr", iid_val, 8'h01);
    thr_empty = 0; tick(); thr_empty = 1; tick(); chk("R8 reset", iid_val, 8'h02);
    thr_empty = 0; tick(); chk("R8 low clr", iid_val, 8'h01);
    thr_empty = 1; tick(); rx_ready = 1; tick(); chk("R4 rx over tx", iid_val, 8'h04);
    rd_iid = 1; tick(); rd_iid = 0; rx_ready = 0; tick(); chk("R8 hidden kept", iid_val, 8'h02);
    thr_empty = 0; tick();
    // R9 / R10
    line_cts = 1; tick(); chk("R9 cts", msr_val, 8'h11); chk("R4 modem", iid_val, 8'h00);
    rd_msr = 1; tick(); rd_msr = 0; chk("R10 clr", msr_val, 8'h10); chk("R3 after msr", iid_val, 8'h01);
    line_dcd = 1; rd_msr = 1; tick(); rd_msr = 0; chk("R10 collide", msr_val, 8'h98);
    line_ri = 1; tick(); chk("R9 ri", msr_val, 8'hDC);
    line_dsr = 1; tick(); chk("R9 dsr", msr_val, 8'hFE);
    rd_msr = 1; tick(); rd_msr = 0; chk("R10 clr all", msr_val, 8'hF0);
    {line_dcd, line_ri, line_dsr, line_cts} = 4'h0; tick(); chk("R10 fall", msr_val, 8'h0F);
    rd_msr = 1; tick(); rd_msr = 0; chk("R10 clr2", msr_val, 8'h00);
    // R11 gate
    mc_out2 = 0; thr_empty = 1; tick();
    chk("R11 gated iid", iid_val, 8'h02); chk("R11 gated irq", {7'h0, irq}, 8'h00);
    mc_out2 = 1; tick(); chk("R11 ungated", {7'h0, irq}, 8'h01);
    thr_empty = 0; tick();
    // R4 enable masking
    wr_ier = 1; wr_data = 4'h0; tick(); wr_ier = 0;
    ls_err = 1; tick(); ls_err = 0; chk("R4 masked", iid_val, 8'h01);
    wr_ier = 1; wr_data = 4'h4; tick(); wr_ier = 0; chk("R4 unmasked", iid_val, 8'h06);
    rd_lsr = 1; tick(); rd_lsr = 0; chk("R4 idle", iid_val, 8'h01);
    wr_ier = 1; wr_data = 4'hF; tick(); wr_ier = 0;
    // R12 loopback (mc_out2 = 1)
    loop_en = 1; mc_rts = 1; line_cts = 1; line_ri = 1; tick(); chk("R12 loop", msr_val, 8'h99);
    rd_msr = 1; tick(); rd_msr = 0; chk("R12 clr", msr_val, 8'h90);
    line_dsr = 1; tick(); chk("R12 ext ignored", msr_val, 8'h90);
    loop_en = 0; tick(); chk("R12 exit", msr_val, 8'h7E);
    rd_msr = 1; tick(); rd_msr = 0;
    {line_dcd, line_ri, line_dsr, line_cts} = 4'h0; mc_rts = 0; tick();
    rd_msr = 1; tick(); rd_msr = 0; tick();
    chk("R3 final", iid_val, 8'h01);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule